// File: doc/BRIEF.md
# Mixed-Granularity Condition Register File

This block holds a 32-bit condition register that is split into eight 4-bit fields. It serves two kinds of consumer at once. One read port returns the whole register. Three independent narrow read ports each return one field, chosen by a 3-bit index. A unit that needs three fields and the full value in the same cycle can therefore get all of them without waiting, and the number of ports equals the demand of the hungriest consumer.

Writes arrive on two ports. The wide write port carries 32 data bits and an 8-bit field-enable mask, and only the fields that the mask selects change. The narrow write port replaces one field, chosen by index. When both ports target the same field in one cycle, the narrow port's data is kept. Every read port is write-through: in the cycle of a write, the ports already show the value the register will hold after the clock edge. The block does not arbitrate between units and does not decode field numbers from instructions.

Top module: `crf_top`

## Requirements
- R1: A synchronous active-high reset clears all 32 bits to zero. After reset, with no write, the full read port returns 0x00000000.
- R2: The full read port returns the complete register. Field 0 sits in bits 31:28 and field 7 sits in bits 3:0, with field i at bits (31-4i):(28-4i).
- R3: Each of the three field read ports independently returns the field named by its own 3-bit index. Index 0 selects bits 31:28 and index 7 selects bits 3:0. Any two ports may use the same index.
- R4: When the wide write is enabled, mask bit i set means field i takes the matching bits of the wide write data. Fields whose mask bit is clear keep their old value.
- R5: When the wide write enable is low, the mask and data on the wide port have no effect on the register.
- R6: When the narrow write is enabled, only the indexed field takes the 4-bit narrow write data, and the other seven fields are unchanged.
- R7: If the narrow write and the wide write both update the same field in one cycle, that field takes the narrow write data. The other masked fields still take the wide data.
- R8: In a cycle with any write, the full read port and all field read ports already return the post-write value. The register holds that value from the next clock edge on.
- R9: In a cycle with no write, the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| full_wr_en | input | 1 | Wide write enable |
| full_wr_mask | input | 8 | Per-field enable for the wide write, bit i selects field i |
| full_wr_data | input | 32 | Wide write data |
| fld_wr_en | input | 1 | Narrow write enable |
| fld_wr_idx | input | 3 | Field index for the narrow write |
| fld_wr_data | input | 4 | Narrow write data |
| fld_rd_idx | input | 9 | Three packed 3-bit field indices, port p at bits 3p+2:3p |
| fld_rd_data | output | 12 | Three packed 4-bit fields, port p at bits 4p+3:4p |
| full_rd_data | output | 32 | Full register value, write-through |

## Verification
The bench drives a set of directed patterns and then a long stretch of random ones. The directed patterns are: a full mask, a zero mask with the wide enable low, single-bit masks that walk across the fields, a narrow write to each index, and narrow and wide writes that collide on one field. The walking masks and the narrow writes show whether the field order is reversed or shifted. The collisions show which port has priority and whether the other masked fields still update. The cycles where the enable is low but the mask and data are busy show that the wide port is gated. Random indices are applied to the three read ports in every cycle, including repeated indices. Each output is compared with the post-write value, so a design that reads the old value during a write is caught.

// File: rtl/crf_pkg.sv
package crf_pkg;

    localparam int FIELD_W    = 4;
    localparam int NUM_FIELDS = 8;
    localparam int REG_W      = FIELD_W * NUM_FIELDS;
    localparam int IDX_W      = $clog2(NUM_FIELDS);
    localparam int NUM_FRD    = 3;

    typedef logic [REG_W-1:0]      creg_t;
    typedef logic [FIELD_W-1:0]    field_t;
    typedef logic [IDX_W-1:0]      fidx_t;
    typedef logic [NUM_FIELDS-1:0] fmask_t;

    typedef struct packed {
        logic   en;
        fmask_t mask;
        creg_t  data;
    } wide_wr_t;

    typedef struct packed {
        logic   en;
        fidx_t  idx;
        field_t data;
    } narrow_wr_t;

    // Field 0 is the most significant field.
    function automatic int field_lsb(input int idx);
        return (NUM_FIELDS - 1 - idx) * FIELD_W;
    endfunction

    function automatic field_t get_field(input creg_t val, input fidx_t idx);
        return field_t'(val >> field_lsb(int'(idx)));
    endfunction

endpackage

// File: rtl/crf_write_merge.sv
module crf_write_merge
    import crf_pkg::*;
(
    input  creg_t      cur,
    input  wide_wr_t   wide,
    input  narrow_wr_t narrow,
    output creg_t      nxt
);

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        localparam int LSB = field_lsb(g);
        logic take_wide;
        logic take_narrow;

        always_comb begin
            take_wide   = wide.en & wide.mask[g];
            take_narrow = narrow.en & (narrow.idx == fidx_t'(g));
            if (take_narrow)
                nxt[LSB +: FIELD_W] = narrow.data;
            else if (take_wide)
                nxt[LSB +: FIELD_W] = wide.data[LSB +: FIELD_W];
            else
                nxt[LSB +: FIELD_W] = cur[LSB +: FIELD_W];
        end
    end

endmodule

// File: rtl/crf_field_read.sv
module crf_field_read
    import crf_pkg::*;
(
    input  creg_t  val,
    input  fidx_t  idx,
    output field_t data
);

    always_comb data = get_field(val, idx);

endmodule

// File: rtl/crf_top.sv
module crf_top
    import crf_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       full_wr_en,
    input  logic [NUM_FIELDS-1:0]      full_wr_mask,
    input  logic [REG_W-1:0]           full_wr_data,
    input  logic                       fld_wr_en,
    input  logic [IDX_W-1:0]           fld_wr_idx,
    input  logic [FIELD_W-1:0]         fld_wr_data,
    input  logic [NUM_FRD*IDX_W-1:0]   fld_rd_idx,
    output logic [NUM_FRD*FIELD_W-1:0] fld_rd_data,
    output logic [REG_W-1:0]           full_rd_data
);

    creg_t      creg_q;
    creg_t      creg_nxt;
    wide_wr_t   wide;
    narrow_wr_t narrow;

    always_comb begin
        wide.en     = full_wr_en;
        wide.mask   = full_wr_mask;
        wide.data   = full_wr_data;
        narrow.en   = fld_wr_en;
        narrow.idx  = fld_wr_idx;
        narrow.data = fld_wr_data;
    end

    crf_write_merge u_merge (
        .cur    (creg_q),
        .wide   (wide),
        .narrow (narrow),
        .nxt    (creg_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) creg_q <= '0;
        else     creg_q <= creg_nxt;
    end

    // Write-through: all reads see the merged value.
    assign full_rd_data = creg_nxt;

    for (genvar p = 0; p < NUM_FRD; p++) begin : g_rd
        crf_field_read u_rd (
            .val  (creg_nxt),
            .idx  (fld_rd_idx[p*IDX_W +: IDX_W]),
            .data (fld_rd_data[p*FIELD_W +: FIELD_W])
        );
    end

endmodule

// File: rtl/crf_top_chk.sv
module crf_top_chk
    import crf_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       full_wr_en,
    input logic [NUM_FIELDS-1:0]      full_wr_mask,
    input logic [REG_W-1:0]           full_wr_data,
    input logic                       fld_wr_en,
    input logic [IDX_W-1:0]           fld_wr_idx,
    input logic [FIELD_W-1:0]         fld_wr_data,
    input logic [NUM_FRD*IDX_W-1:0]   fld_rd_idx,
    input logic [NUM_FRD*FIELD_W-1:0] fld_rd_data,
    input logic [REG_W-1:0]           full_rd_data
);

    logic  armed;
    creg_t wide_bits;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    always_comb begin
        for (int i = 0; i < NUM_FIELDS; i++)
            wide_bits[field_lsb(i) +: FIELD_W] = {FIELD_W{full_wr_mask[i]}};
    end

    // R1: reset leaves a zero register
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (full_wr_en || fld_wr_en || full_rd_data == '0));

    // R3: every narrow read port agrees with the full read port
    for (genvar p = 0; p < NUM_FRD; p++) begin : g_r3
        a_r3_field_port: assert property (@(posedge clk) disable iff (rst)
            fld_rd_data[p*FIELD_W +: FIELD_W]
                == get_field(full_rd_data, fld_rd_idx[p*IDX_W +: IDX_W]));
    end

    // R4: masked fields carry the wide data when no narrow write is active
    a_r4_wide_masked: assert property (@(posedge clk) disable iff (rst)
        (full_wr_en && !fld_wr_en)
            |-> (((full_rd_data ^ full_wr_data) & wide_bits) == '0));

    // R5: enable low with busy mask and data keeps the value
    a_r5_wide_gated: assert property (@(posedge clk) disable iff (rst)
        (armed && !full_wr_en && !fld_wr_en && full_wr_mask != '0)
            |=> (full_rd_data == $past(full_rd_data) || full_wr_en || fld_wr_en));

    // R6 and R7: the narrow write always lands in its field
    a_r7_narrow_wins: assert property (@(posedge clk) disable iff (rst)
        fld_wr_en |-> get_field(full_rd_data, fld_wr_idx) == fld_wr_data);

    // R9: the value is held across cycles with no write
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (armed && !full_wr_en && !fld_wr_en)
            |=> (full_wr_en || fld_wr_en || full_rd_data == $past(full_rd_data)));

endmodule

bind crf_top crf_top_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .full_wr_en   (full_wr_en),
    .full_wr_mask (full_wr_mask),
    .full_wr_data (full_wr_data),
    .fld_wr_en    (fld_wr_en),
    .fld_wr_idx   (fld_wr_idx),
    .fld_wr_data  (fld_wr_data),
    .fld_rd_idx   (fld_rd_idx),
    .fld_rd_data  (fld_rd_data),
    .full_rd_data (full_rd_data)
);

// File: tb/crf_top_tb.sv
`timescale 1ns/1ps
module crf_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        full_wr_en = 1'b0;
    logic [7:0]  full_wr_mask = '0;
    logic [31:0] full_wr_data = '0;
    logic        fld_wr_en = 1'b0;
    logic [2:0]  fld_wr_idx = '0;
    logic [3:0]  fld_wr_data = '0;
    logic [8:0]  fld_rd_idx = '0;
    logic [11:0] fld_rd_data;
    logic [31:0] full_rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] model = '0;

    always #2.5 clk = ~clk;

    crf_top u_dut (
        .clk(clk), .rst(rst),
        .full_wr_en(full_wr_en), .full_wr_mask(full_wr_mask), .full_wr_data(full_wr_data),
        .fld_wr_en(fld_wr_en), .fld_wr_idx(fld_wr_idx), .fld_wr_data(fld_wr_data),
        .fld_rd_idx(fld_rd_idx), .fld_rd_data(fld_rd_data), .full_rd_data(full_rd_data)
    );

    function automatic logic [3:0] fld_of(input logic [31:0] v, input int idx);
        return 4'((v >> ((7 - idx) * 4)) & 32'hF);
    endfunction

    function automatic logic [31:0] put_fld(input logic [31:0] v, input int idx,
                                            input logic [3:0] d);
        int sh = (7 - idx) * 4;
        return (v & ~(32'hF << sh)) | ({28'd0, d} << sh);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, compare mid-phase, commit at the rising edge.
    task automatic step(input string tag,
                        input logic we, input logic [7:0] m, input logic [31:0] wd,
                        input logic fe, input int fi, input logic [3:0] fd,
                        input int r0, input int r1, input int r2);
        logic [31:0] exp;
        full_wr_en = we; full_wr_mask = m; full_wr_data = wd;
        fld_wr_en = fe; fld_wr_idx = 3'(fi); fld_wr_data = fd;
        fld_rd_idx = {3'(r2), 3'(r1), 3'(r0)};
        exp = model;
        if (we)
            for (int i = 0; i < 8; i++)
                if (m[i]) exp = put_fld(exp, i, fld_of(wd, i));
        if (fe) exp = put_fld(exp, fi, fd);
        #1;
        check({tag, " full"}, full_rd_data, exp);
        check({tag, " port0"}, {28'd0, fld_rd_data[3:0]},  {28'd0, fld_of(exp, r0)});
        check({tag, " port1"}, {28'd0, fld_rd_data[7:4]},  {28'd0, fld_of(exp, r1)});
        check({tag, " port2"}, {28'd0, fld_rd_data[11:8]}, {28'd0, fld_of(exp, r2)});
        @(posedge clk);
        model = exp;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 50000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model = '0;
        // R1: cleared after reset
        step("R1", 0, 8'h00, 32'h0, 0, 0, 4'h0, 0, 3, 7);
        // R2 and R8: full mask write, bypass visible in the write cycle
        step("R2_R8", 1, 8'hFF, 32'h0123_4567, 0, 0, 4'h0, 0, 1, 7);
        // R9: hold
        step("R9", 0, 8'h00, 32'h0, 0, 0, 4'h0, 2, 4, 6);
        // R3: each index on every port, repeated indices
        for (int i = 0; i < 8; i++)
            step("R3", 0, 8'h00, 32'h0, 0, 0, 4'h0, i, 7 - i, i);
        // R5: busy mask and data with enable low
        step("R5", 0, 8'hFF, 32'hFFFF_FFFF, 0, 0, 4'h0, 0, 5, 7);
        step("R5", 0, 8'h5A, 32'hDEAD_BEEF, 0, 0, 4'h0, 1, 2, 3);
        // R4: walking single-bit mask
        for (int i = 0; i < 8; i++)
            step("R4", 1, 8'(1 << i), 32'hA5C3_96E1 ^ (32'h1111_1111 * i), 0, 0, 4'h0, i, 0, 7);
        // R6: narrow write to each index
        for (int i = 0; i < 8; i++)
            step("R6", 0, 8'h00, 32'h0, 1, i, 4'(i + 9), i, (i + 1) % 8, 0);
        // R7: collision, narrow wins, other masked fields still written
        step("R7", 1, 8'hFF, 32'hAAAA_AAAA, 1, 3, 4'h5, 3, 2, 4);
        step("R7", 1, 8'h81, 32'h9000_0009, 1, 0, 4'h6, 0, 7, 0);
        step("R7", 1, 8'h0F, 32'h1234_5678, 1, 2, 4'hC, 2, 4, 7);
        step("R9", 0, 8'h00, 32'h0, 0, 0, 4'h0, 0, 3, 7);
        // Random traffic across all requirements
        for (int n = 0; n < 400; n++)
            step("R8_rand", 1'($urandom_range(0, 1)), 8'($urandom), $urandom,
                 1'($urandom_range(0, 1)), $urandom_range(0, 7), 4'($urandom),
                 $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7));
        // R1: reset in the middle of traffic clears the register
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model = '0;
        step("R1", 0, 8'hFF, 32'hFFFF_FFFF, 0, 0, 4'h0, 0, 4, 7);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule